// File: doc/BRIEF.md
# SMBus Register-Pointer Slave

This block is the target side of a two-wire SMBus link. It gives a host read and write access to a 256-entry by 8-bit register file that sits outside the block. SCL and SDA are sampled with the system clock, and SDA is driven open-drain through an output-enable that can only pull the line low. The block detects start, repeated-start and stop conditions and matches its 7-bit device address. It supports three transactions: loading the register pointer, writing the register the pointer selects, and reading that register.

The pointer is kept between transactions. A read that begins directly with the read address therefore returns the register chosen by an earlier transaction. If either bus line stays low for longer than a parameterised number of system clocks, the block treats this as a bus reset. It releases SDA and waits for a fresh start condition.

The register file connects through an address output and a write-data output, both driven from internal state. A one-cycle write strobe commits a write. A combinational read-data input returns the addressed entry.

Top module: `smb_ptr_slave`

## Requirements
- R1: The device address is 7'h2C, carried in bits 7..1 of the first byte after a start. Bit 0 is R/W, with 0 for write and 1 for read, so the bytes are 58h and 59h. Every byte is sent MSB first. On a match the slave pulls SDA low during the ninth clock.
- R2: When the address does not match, the slave never drives SDA and never writes a register until the next start or stop condition.
- R3: In a write-addressed transaction, the slave loads the first byte after the address into the pointer and ACKs it. A stop at that point performs no register write.
- R4: Every further byte in the same write transaction, with no repeated start, is ACKed and written to the register the pointer selects. The pointer does not advance, so repeated bytes go to the same register.
- R5: Each written byte produces exactly one reg_wr pulse lasting one system clock. During that pulse, reg_addr equals the pointer and reg_wdata equals the byte.
- R6: A repeated start followed by 59h makes the slave ACK the address. It then sends the register the pointer selects, MSB first, starting with the low phase that follows the ACK clock.
- R7: A read opened directly with start and 59h returns the register selected by the pointer stored in an earlier transaction.
- R8: If SCL or SDA stays low for TIMEOUT_CYC system clocks, the slave releases SDA and goes idle, even in the middle of a transfer. It ignores clocks until a new start, and the pointer keeps its value.
- R9: The slave pulls SDA low only while SCL is low.
- R10: After the host NACKs a read byte, SDA stays released through the following stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_oe | output | 1 | High pulls SDA low |
| reg_addr | output | 8 | Register file address (pointer) |
| reg_wdata | output | 8 | Register write data |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Combinational register read data |

## Verification
A line change passes through two synchronizer flops and one edge-detect stage, so sda_oe and reg_wr change on the third system clock after the SCL edge that causes them. The bench holds each SCL half-period for 20 system clocks and samples acknowledge and data bits at the middle of the SCL high phase, well after any update is due. Register writes are compared in a monitor at the falling clock edge on each reg_wr pulse, against a queue of expected address and data pairs filled by the driver. The bus-reset check samples sda_oe only after the line has been held low for TIMEOUT_CYC plus a margin of clocks.

// File: rtl/smb_ptr_slave.sv
module smb_ptr_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h2C,
  parameter int         TIMEOUT_CYC = 875000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_wr,
  input  logic [7:0] reg_rdata
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_PTR, S_WR, S_ACK, S_TX, S_HACK, S_IGN} st_t;

  st_t        state, nxt;
  logic [2:0] scl_sy, sda_sy, cnt;
  logic [7:0] sh, tx, ptr;
  logic       done;
  logic [TW-1:0] tmo_cnt;

  wire scl_q = scl_sy[1];
  wire scl_p = scl_sy[2];
  wire sda_q = sda_sy[1];
  wire sda_p = sda_sy[2];

  wire start_det = scl_q & scl_p & sda_p & ~sda_q;
  wire stop_det  = scl_q & scl_p & ~sda_p & sda_q;
  wire scl_rise  = scl_q & ~scl_p;
  wire scl_fall  = ~scl_q & scl_p;
  wire tmo_hit   = (tmo_cnt == TW'(TIMEOUT_CYC));
  wire rx_st     = (state == S_DEV) || (state == S_PTR) || (state == S_WR);

  assign reg_addr  = ptr;
  assign reg_wdata = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_in};
      sda_sy <= {sda_sy[1:0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              tmo_cnt <= '0;
    else if (scl_q && sda_q) tmo_cnt <= '0;
    else if (!tmo_hit)       tmo_cnt <= tmo_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      nxt    <= S_IDLE;
      cnt    <= '0;
      sh     <= '0;
      tx     <= '0;
      ptr    <= '0;
      done   <= 1'b0;
      sda_oe <= 1'b0;
      reg_wr <= 1'b0;
    end else begin
      reg_wr <= 1'b0;
      if (start_det) begin
        state  <= S_DEV;
        cnt    <= '0;
        done   <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_det || tmo_hit) begin
        state  <= S_IDLE;
        cnt    <= '0;
        done   <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        if (scl_rise) begin
          if (rx_st) begin
            sh  <= {sh[6:0], sda_q};
            cnt <= cnt + 1'b1;
            if (cnt == 3'd7) done <= 1'b1;
          end
          if (state == S_TX) cnt <= cnt + 1'b1;
          if (state == S_HACK) begin
            if (sda_q) state <= S_IGN;
            else begin
              state <= S_ACK;
              nxt   <= S_TX;
            end
          end
        end
        if (scl_fall) begin
          case (state)
            S_DEV: if (done) begin
              done <= 1'b0;
              if (sh[7:1] == DEV_ADDR) begin
                sda_oe <= 1'b1;
                nxt    <= sh[0] ? S_TX : S_PTR;
                state  <= S_ACK;
              end else begin
                state <= S_IGN;
              end
            end
            S_PTR: if (done) begin
              done   <= 1'b0;
              ptr    <= sh;
              sda_oe <= 1'b1;
              nxt    <= S_WR;
              state  <= S_ACK;
            end
            S_WR: if (done) begin
              done   <= 1'b0;
              reg_wr <= 1'b1;
              sda_oe <= 1'b1;
              nxt    <= S_WR;
              state  <= S_ACK;
            end
            S_ACK: begin
              state <= nxt;
              if (nxt == S_TX) begin
                tx     <= reg_rdata;
                sda_oe <= ~reg_rdata[7];
              end else begin
                sda_oe <= 1'b0;
              end
            end
            S_TX: begin
              if (cnt == 3'd0) begin
                sda_oe <= 1'b0;
                state  <= S_HACK;
              end else begin
                sda_oe <= ~tx[~cnt];
              end
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/smb_ptr_slave_chk.sv
module smb_ptr_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_q,
  input logic start_det,
  input logic stop_det,
  input logic tmo_hit,
  input logic sda_oe,
  input logic reg_wr
);
  a_r9_pull_while_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_q));

  a_r5_wr_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  a_r8_timeout_releases: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> !sda_oe);

  a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  a_r2_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);
endmodule

bind smb_ptr_slave smb_ptr_slave_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .start_det(start_det),
  .stop_det(stop_det), .tmo_hit(tmo_hit), .sda_oe(sda_oe), .reg_wr(reg_wr)
);

// File: tb/smb_ptr_slave_tb_top.sv
module smb_ptr_slave_tb_top;
  localparam int TMO = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_h = 1'b1;
  logic sda_h = 1'b1;
  logic sda_oe, reg_wr;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [15:0] exp_q [$];
  int checks = 0, errors = 0, wr_seen = 0;
  bit finished = 1'b0;

  wire bus_sda = sda_h & ~sda_oe;

  always #2 clk = ~clk;

  smb_ptr_slave #(.DEV_ADDR(7'h2C), .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_h), .sda_in(bus_sda), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) if (reg_wr) mem[reg_addr] <= reg_wdata;
  assign reg_rdata = mem[reg_addr];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compare each write strobe against the driver's queue (R4, R5)
  always @(negedge clk) begin
    if (reg_wr) begin
      wr_seen++;
      if (exp_q.size() == 0) check(1'b0, "R5 unexpected write", {reg_addr, reg_wdata}, 0);
      else begin
        automatic logic [15:0] e = exp_q.pop_front();
        check({reg_addr, reg_wdata} == e, "R5 write addr/data", {reg_addr, reg_wdata}, e);
      end
    end
  end

  // R9: pulling SDA only while SCL is low
  always @(posedge sda_oe) if (rst_n) check(scl_h == 1'b0, "R9 pull with SCL high", scl_h, 0);

  task automatic q(); repeat (10) @(negedge clk); endtask

  task automatic bstart();
    sda_h = 1'b1; q(); scl_h = 1'b1; q(); sda_h = 1'b0; q(); scl_h = 1'b0; q();
  endtask

  task automatic bstop();
    sda_h = 1'b0; q(); scl_h = 1'b1; q(); sda_h = 1'b1; q();
  endtask

  task automatic clk_bit(input logic b, output logic smp);
    sda_h = b; q(); scl_h = 1'b1; q(); smp = bus_sda; q(); scl_h = 1'b0; q();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic nack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, nack);
  endtask

  task automatic rbyte(input logic host_nack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(host_nack, s);
  endtask

  task automatic set_ptr(input logic [7:0] p);
    logic a;
    bstart();
    wbyte(8'h58, a); check(a == 1'b0, "R1 address ACK", a, 0);
    wbyte(p, a);     check(a == 1'b0, "R3 pointer ACK", a, 0);
  endtask

  task automatic wr_reg(input logic [7:0] p, input logic [7:0] d);
    logic a;
    set_ptr(p);
    exp_q.push_back({p, d});
    exp_mem[p] = d;
    wbyte(d, a); check(a == 1'b0, "R4 data ACK", a, 0);
    bstop();
  endtask

  task automatic rd_restart(input logic [7:0] p, input string req);
    logic a;
    logic [7:0] d;
    set_ptr(p);
    bstart();
    wbyte(8'h59, a); check(a == 1'b0, "R6 read address ACK", a, 0);
    rbyte(1'b1, d);  check(d == exp_mem[p], req, d, exp_mem[p]);
    bstop();
    check(sda_oe == 1'b0, "R10 released after NACK and stop", sda_oe, 0);
  endtask

  task automatic rd_plain(input logic [7:0] p, input string req);
    logic a;
    logic [7:0] d;
    bstart();
    wbyte(8'h59, a); check(a == 1'b0, "R7 read address ACK", a, 0);
    rbyte(1'b1, d);  check(d == exp_mem[p], req, d, exp_mem[p]);
    bstop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a;
    int w0;
    logic [7:0] d;
    for (int i = 0; i < 256; i++) begin
      mem[i] = i[7:0] ^ 8'hA5;
      exp_mem[i] = i[7:0] ^ 8'hA5;
    end
    repeat (5) @(negedge clk);
    check(sda_oe == 1'b0 && reg_wr == 1'b0, "reset outputs idle", {sda_oe, reg_wr}, 0);
    rst_n = 1'b1;
    q();

    // R3: pointer set only, no write
    w0 = wr_seen;
    set_ptr(8'h22);
    bstop();
    q();
    check(wr_seen == w0, "R3 no write on pointer set", wr_seen - w0, 0);
    rd_plain(8'h22, "R7 plain read uses stored pointer");

    // R4 single write, R6 read back through repeated start
    wr_reg(8'h10, 8'h3C);
    rd_restart(8'h10, "R6 restart read data");
    rd_plain(8'h10, "R7 plain read after restart read");
    rd_restart(8'h7F, "R6 restart read of untouched register");

    // R4 two data bytes go to the same register
    set_ptr(8'h40);
    exp_q.push_back({8'h40, 8'h11});
    exp_q.push_back({8'h40, 8'h22});
    exp_mem[8'h40] = 8'h22;
    wbyte(8'h11, a); check(a == 1'b0, "R4 first data ACK", a, 0);
    wbyte(8'h22, a); check(a == 1'b0, "R4 second data ACK", a, 0);
    bstop();
    rd_restart(8'h40, "R4 no pointer advance");
    rd_restart(8'h41, "R4 neighbour untouched");

    // R2: foreign address ignored
    w0 = wr_seen;
    bstart();
    wbyte(8'h5A, a); check(a == 1'b1, "R2 no ACK for foreign address", a, 1);
    wbyte(8'h40, a); check(a == 1'b1, "R2 no ACK on later byte", a, 1);
    wbyte(8'h99, a); check(a == 1'b1, "R2 no ACK on data byte", a, 1);
    bstop();
    check(wr_seen == w0, "R2 no write strobe", wr_seen - w0, 0);
    rd_restart(8'h40, "R2 register unchanged");

    // R8: bus reset in the middle of a read
    wr_reg(8'h05, 8'h00);
    bstart();
    wbyte(8'h59, a); check(a == 1'b0, "R8 setup read ACK", a, 0);
    clk_bit(1'b1, a); check(a == 1'b0, "R8 setup first data bit", a, 0);
    check(sda_oe == 1'b1, "R8 slave pulling before timeout", sda_oe, 1);
    repeat (TMO + 50) @(negedge clk);
    check(sda_oe == 1'b0, "R8 released after timeout", sda_oe, 0);
    w0 = wr_seen;
    wbyte(8'h58, a); check(a == 1'b1, "R8 ignores clocks without start", a, 1);
    check(wr_seen == w0, "R8 no write after timeout", wr_seen - w0, 0);
    bstop();
    rd_plain(8'h05, "R8 pointer kept across bus reset");

    q();
    check(exp_q.size() == 0, "R5 all expected writes seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule